// File: doc/BRIEF.md
# Multi-Lane Router Input Port with Class-Reserved Lanes

This block is the receiving side of one router port in a mesh network whose packets travel wormhole style: a header flit, then body flits, with the last flit marked as tail. The port does not keep a single queue. It spreads arriving packets over two or four parallel lanes, so that a packet whose next hop is congested does not hold back packets queued behind it. Lanes are not tied to any output. The head flit of each lane may go toward whatever output the routing stage picks, and the congestion seen downstream is reported back per lane.

Two lanes are reserved by traffic class. Lane 0 takes only packets that are still on their way to the wireless router of their subnet. Lane 1 takes only packets that head straight for their destination node. Any further lanes are shared by both classes. The class is read from one bit of the header flit. A header takes the reserved lane of its class when that lane is free, and otherwise the lowest-numbered free shared lane. If neither is free, the port withholds ready for that header. Body flits follow their header into the same lane until the tail flit closes the packet. On the output side a round-robin arbiter picks one flit per cycle from the lanes that hold data and are not blocked.

Top module: `lane_input_port`

## Requirements
- R1: After reset every lane is empty: out_valid is 0, and a header of either class presented at in_data gets in_ready 1.
- R2: A header with in_data bit WL_BIT (default 63) set to 1 (wireless class) is written to lane 0 when lane 0 is free, otherwise to the lowest-numbered free lane of index 2 or more. It never enters lane 1.
- R3: A header with bit WL_BIT at 0 (destination class) is written to lane 1 when lane 1 is free, otherwise to the lowest-numbered free lane of index 2 or more. It never enters lane 0.
- R4: A lane is free for a new header only when it holds no flit and no packet is open in it. A lane becomes free again once it has drained.
- R5: When no lane the header's class may use is free, in_ready is 0 while that header is presented, and the header is not taken.
- R6: A flit with in_head 0 goes to the lane of the open packet. The flit with in_tail 1 (a single-flit packet included) closes the packet.
- R7: A non-header flit sees in_ready 0 while its lane already holds LANE_DEPTH (default 4) flits, and it is taken once a flit has left that lane.
- R8: Each lane delivers its flits in arrival order. out_data, out_head and out_tail repeat what was written, and out_lane gives the index of the lane the flit came from.
- R9: Lanes that hold a flit and are not blocked are served round-robin. After lane g has been served, the search for the next grant starts at lane g+1 and wraps.
- R10: A lane whose out_block bit is 1 is not served, and the other lanes keep delivering.
- R11: out_valid is 1 exactly when some unblocked lane holds a flit. While out_ready is 0 no flit is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Upstream flit valid |
| in_head | input | 1 | Flit is a packet header |
| in_tail | input | 1 | Flit is the last of its packet |
| in_data | input | FLIT_W | Flit payload; bit WL_BIT of a header gives the class |
| in_ready | output | 1 | Port takes the presented flit this cycle |
| out_block | input | NUM_LANES | Per-lane flag: the route of this lane's head flit is congested |
| out_ready | input | 1 | Downstream takes the offered flit |
| out_valid | output | 1 | A flit is offered |
| out_head | output | 1 | Offered flit is a header |
| out_tail | output | 1 | Offered flit is a tail |
| out_data | output | FLIT_W | Offered flit payload |
| out_lane | output | $clog2(NUM_LANES) | Lane the offered flit comes from |

## Verification
The hardest state to reach is one where every lane is taken at once and the next header finds nothing eligible. The reserved lanes, the shared lanes and the open-packet rule must all line up, and the output must not drain any lane in the meantime. The stimulus table holds out_ready low while it fills both reserved lanes, then sends one packet of each class into the shared lanes, then offers one more header of each class and expects both to be refused. The same filled state is then drained. The order of flits leaving the port shows which lane each packet entered and how the round-robin pointer moved. A separate test blocks one loaded lane to show that the other lanes keep moving past it.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;

   typedef enum logic {
      CLS_DEST     = 1'b0,
      CLS_WIRELESS = 1'b1
   } flit_class_e;

   localparam int RSV_WL_LANE  = 0;
   localparam int RSV_DST_LANE = 1;
   localparam int FIRST_SHARED = 2;

   function automatic int reserved_lane(flit_class_e c);
      return (c == CLS_WIRELESS) ? RSV_WL_LANE : RSV_DST_LANE;
   endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
   parameter int W     = 66,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wr_data,
   input  logic         pop,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("lane_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;

   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R8

endmodule

// File: rtl/lane_pick.sv
module lane_pick
   import lane_port_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0]         free,
   input  flit_class_e          cls,
   output logic                 found,
   output logic [$clog2(N)-1:0] sel
);
   localparam int IW = $clog2(N);

   always_comb begin
      int rsv;
      rsv   = reserved_lane(cls);
      found = 1'b0;
      sel   = '0;
      if (free[rsv]) begin
         found = 1'b1;
         sel   = IW'(rsv);
      end else begin
         for (int i = FIRST_SHARED; i < N; i++) begin
            if (!found && free[i]) begin
               found = 1'b1;
               sel   = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/lane_rr_arb.sv
module lane_rr_arb #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 advance,
   output logic                 grant_vld,
   output logic [$clog2(N)-1:0] grant_idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] ptr;

   always_comb begin
      logic [IW-1:0] idx;
      grant_vld = 1'b0;
      grant_idx = '0;
      for (int off = 0; off < N; off++) begin
         idx = ptr + IW'(off);
         if (!grant_vld && req[idx]) begin
            grant_vld = 1'b1;
            grant_idx = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ptr <= '0;
      else if (advance && grant_vld) ptr <= grant_idx + 1'b1;
   end

   AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> req[grant_idx]); // R9
   AST_GRANT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> grant_vld); // R11

endmodule

// File: rtl/lane_input_port.sv
module lane_input_port
   import lane_port_pkg::*;
#(
   parameter int FLIT_W     = 64,
   parameter int NUM_LANES  = 4,
   parameter int LANE_DEPTH = 4,
   parameter int WL_BIT     = 63
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_head,
   input  logic                         in_tail,
   input  logic [FLIT_W-1:0]            in_data,
   output logic                         in_ready,
   input  logic [NUM_LANES-1:0]         out_block,
   input  logic                         out_ready,
   output logic                         out_valid,
   output logic                         out_head,
   output logic                         out_tail,
   output logic [FLIT_W-1:0]            out_data,
   output logic [$clog2(NUM_LANES)-1:0] out_lane
);
   localparam int LIW = $clog2(NUM_LANES);
   localparam int EW  = FLIT_W + 2;

   generate
      if (NUM_LANES != 2 && NUM_LANES != 4) begin : g_bad_lanes
         $error("lane_input_port: NUM_LANES must be 2 or 4");
      end
      if (WL_BIT < 0 || WL_BIT >= FLIT_W) begin : g_bad_bit
         $error("lane_input_port: WL_BIT outside the flit");
      end
   endgenerate

   flit_class_e           cls;
   logic [NUM_LANES-1:0]  empty, full, free, push, pop, req;
   logic [EW-1:0]         rd_entry [NUM_LANES];
   logic                  hdr_found;
   logic [LIW-1:0]        hdr_lane, tgt_lane, gnt_idx;
   logic                  open_vld;
   logic [LIW-1:0]        open_lane;
   logic                  acc, gnt_vld;

   assign cls = flit_class_e'(in_data[WL_BIT]);

   always_comb begin
      for (int i = 0; i < NUM_LANES; i++) begin
         free[i] = empty[i] && !(open_vld && open_lane == LIW'(i));
         req[i]  = !empty[i] && !out_block[i];
      end
   end

   lane_pick #(.N(NUM_LANES)) u_pick (
      .free  (free),
      .cls   (cls),
      .found (hdr_found),
      .sel   (hdr_lane)
   );

   assign tgt_lane = in_head ? hdr_lane : open_lane;
   assign in_ready = in_head ? hdr_found : (open_vld && !full[open_lane]);
   assign acc      = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_vld  <= 1'b0;
         open_lane <= '0;
      end else if (acc) begin
         open_vld <= !in_tail;
         if (in_head) open_lane <= hdr_lane;
      end
   end

   lane_rr_arb #(.N(NUM_LANES)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .advance   (out_ready),
      .grant_vld (gnt_vld),
      .grant_idx (gnt_idx)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_LANES; g++) begin : g_lane
         assign push[g] = acc && (tgt_lane == LIW'(g));
         assign pop[g]  = gnt_vld && out_ready && (gnt_idx == LIW'(g));
         lane_fifo #(.W(EW), .DEPTH(LANE_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push[g]),
            .wr_data ({in_head, in_tail, in_data}),
            .pop     (pop[g]),
            .rd_data (rd_entry[g]),
            .empty   (empty[g]),
            .full    (full[g])
         );
      end
   endgenerate

   assign out_valid = gnt_vld;
   assign out_lane  = gnt_idx;
   assign out_head  = rd_entry[gnt_idx][EW-1];
   assign out_tail  = rd_entry[gnt_idx][EW-2];
   assign out_data  = rd_entry[gnt_idx][FLIT_W-1:0];

   AST_WL_NOT_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_head && cls == CLS_WIRELESS) |-> (tgt_lane != LIW'(RSV_DST_LANE))); // R2
   AST_DST_NOT_WL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_head && cls == CLS_DEST) |-> (tgt_lane != LIW'(RSV_WL_LANE))); // R3
   AST_HDR_EMPTY_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_head) |-> empty[tgt_lane]); // R4
   AST_SERVE_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_block[out_lane]); // R10

endmodule

// File: tb/lane_input_port_tb.sv
`timescale 1ns/1ps
module lane_input_port_tb;
   localparam int FW = 64;
   localparam int NL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0;
   logic [FW-1:0] in_data = '0;
   logic in_ready;
   logic [NL-1:0] out_block = '0;
   logic out_ready = 1'b0;
   logic out_valid, out_head, out_tail;
   logic [FW-1:0] out_data;
   logic [1:0] out_lane;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   lane_input_port u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
      .in_data(in_data), .in_ready(in_ready),
      .out_block(out_block), .out_ready(out_ready),
      .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail),
      .out_data(out_data), .out_lane(out_lane)
   );

   // Fill table: class, packet length, expected lane (-1 = refused)
   localparam int NT = 6;
   localparam int T_CLS  [NT] = '{1, 0, 1, 0, 1, 0};
   localparam int T_LEN  [NT] = '{2, 1, 1, 3, 1, 1};
   localparam int T_LANE [NT] = '{0, 1, 2, 3, -1, -1};
   // Expected drain order: lane, packet, flit index
   localparam int ND = 7;
   localparam int D_LANE [ND] = '{0, 1, 2, 3, 0, 3, 3};
   localparam int D_PKT  [ND] = '{0, 1, 2, 3, 0, 3, 3};
   localparam int D_IDX  [ND] = '{0, 0, 0, 0, 1, 1, 2};

   function automatic logic [FW-1:0] mk(int pkt, int idx, int cls);
      return {cls[0], 55'd0, pkt[3:0], idx[3:0]};
   endfunction

   task automatic check(bit ok, string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic put(logic [FW-1:0] d, logic h, logic t, output logic ok);
      in_valid = 1'b1; in_head = h; in_tail = t; in_data = d;
      @(negedge clk) ok = in_ready;
      @(posedge clk); #1;
      in_valid = 1'b0; in_head = 1'b0; in_tail = 1'b0;
   endtask

   task automatic chk_out(int lane, logic [FW-1:0] d, string req);
      @(negedge clk);
      check(out_valid === 1'b1, req, "out_valid", FW'(out_valid), 1);
      check(out_lane === 2'(lane), req, "out_lane", FW'(out_lane), FW'(lane));
      check(out_data === d, req, "out_data", out_data, d);
      @(posedge clk); #1;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic ok;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "out_valid after reset", FW'(out_valid), 0);
      in_head = 1'b1; in_data = mk(0, 0, 1);
      #1 check(in_ready === 1'b1, "R1", "ready for wireless header", FW'(in_ready), 1);
      in_data = mk(0, 0, 0);
      #1 check(in_ready === 1'b1, "R1", "ready for destination header", FW'(in_ready), 1);
      in_head = 1'b0;
      @(posedge clk); #1;

      // Table walk, out_ready low: fill lanes, then refused headers (R2 R3 R5)
      for (int e = 0; e < NT; e++) begin
         for (int f = 0; f < T_LEN[e]; f++) begin
            put(mk(e, f, T_CLS[e]), f == 0, f == T_LEN[e] - 1, ok);
            if (f == 0) begin
               check(ok === (T_LANE[e] >= 0), (T_LANE[e] < 0) ? "R5" : (T_CLS[e] ? "R2" : "R3"),
                     "header ready", FW'(ok), FW'(T_LANE[e] >= 0));
            end
            if (!ok) break;
         end
      end

      // R11: stalled output keeps offering the same flit
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(out_valid === 1'b1 && out_data === mk(0, 0, 1), "R11", "stalled head",
               out_data, mk(0, 0, 1));
      end
      check(out_head === 1'b1 && out_tail === 1'b0, "R8", "head/tail flags",
            FW'({out_head, out_tail}), 2'b10);
      @(posedge clk); #1;

      // Drain: lanes and round-robin order (R2 R3 R6 R8 R9)
      out_ready = 1'b1;
      for (int k = 0; k < ND; k++)
         chk_out(D_LANE[k], mk(D_PKT[k], D_IDX[k], T_CLS[D_PKT[k]]), "R9");
      @(negedge clk);
      check(out_valid === 1'b0, "R11", "idle after drain", FW'(out_valid), 0);
      @(posedge clk); #1;

      // R4: drained lane 0 is free again; single-flit packet closes itself (R6)
      out_ready = 1'b0;
      put(mk(5, 0, 1), 1'b1, 1'b1, ok);
      check(ok === 1'b1, "R4", "header into drained lane", FW'(ok), 1);
      out_ready = 1'b1;
      chk_out(0, mk(5, 0, 1), "R4");
      out_ready = 1'b0;

      // R7: lane full backpressure
      for (int f = 0; f < 4; f++) begin
         put(mk(9, f, 1), f == 0, 1'b0, ok);
         check(ok === 1'b1, "R7", "fill flit", FW'(ok), 1);
      end
      put(mk(9, 4, 1), 1'b0, 1'b1, ok);
      check(ok === 1'b0, "R7", "flit into full lane", FW'(ok), 0);
      out_ready = 1'b1;
      @(posedge clk); #1;
      out_ready = 1'b0;
      put(mk(9, 4, 1), 1'b0, 1'b1, ok);
      check(ok === 1'b1, "R7", "flit after one left", FW'(ok), 1);
      out_ready = 1'b1;
      for (int f = 1; f < 5; f++) chk_out(0, mk(9, f, 1), "R8");
      out_ready = 1'b0;

      // R10: blocked lane does not stop others
      put(mk(10, 0, 1), 1'b1, 1'b0, ok);
      put(mk(10, 1, 1), 1'b0, 1'b1, ok);
      put(mk(11, 0, 0), 1'b1, 1'b0, ok);
      put(mk(11, 1, 0), 1'b0, 1'b1, ok);
      out_block = 4'b0001;
      out_ready = 1'b1;
      chk_out(1, mk(11, 0, 0), "R10");
      chk_out(1, mk(11, 1, 0), "R10");
      @(negedge clk);
      check(out_valid === 1'b0, "R10", "blocked lane not served", FW'(out_valid), 0);
      @(posedge clk); #1;
      out_block = '0;
      chk_out(0, mk(10, 0, 1), "R10");
      chk_out(0, mk(10, 1, 1), "R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule